// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a byte-register SPI master. A host writes up to four transmit bytes, sets a control byte that picks the frame length, bit order, sampling edge, slave-select mode, loopback and interrupt enable, and then writes the most significant data byte. That write stores the byte and launches a frame. During the frame the same four byte registers act as a shift register: transmit bits leave on `spi_mosi` and receive bits come in from `spi_miso`, or from the block's own output when loopback is set. When the frame is done, the host reads the received bits from the same registers.

The serial clock is the system clock divided by a parameterised half period. It idles low. The slave-select outputs are active low. In automatic mode the chosen select covers exactly one frame. In manual mode software holds the select low across any number of frames and releases it itself. While a frame runs, a busy flag reads as 1 and every host write is dropped.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, all six registers read 0, `spi_sclk` is low, every `spi_ss_n` is high and `irq` is low.
- R2: Register map by `reg_addr`: 0..3 are data bytes, with 3 the most significant. 4 is control: bits [1:0] length, [2] sample on falling edge, [3] LSB first, [4] manual select, [5] loopback, [6] interrupt enable. 5 is select: bits [1:0] slave index, [6] manual select asserted, [7] busy (read only). A write to address 3 while idle stores the byte and starts a frame. Writes to addresses 0..2 do not start one.
- R3: Length 00/01/10/11 gives 8/16/24/32 bits. The frame uses the low-order bits of the data registers, and bits above the frame keep their value. `spi_sclk` gives exactly one rising edge per frame bit.
- R4: With LSB first cleared, bit N-1 is sent first. The first received bit ends at bit N-1 and the last at bit 0.
- R5: With LSB first set, bit 0 is sent first. The first received bit ends at bit 0 and the last at bit N-1.
- R6: Sample edge bit 0 samples `spi_miso` on rising `spi_sclk`, and `spi_mosi` changes after falling edges. Bit 1 samples on falling edges, and `spi_mosi` changes after rising edges.
- R7: In automatic mode only the indexed `spi_ss_n` is low, and only while busy. All selects are high when idle.
- R8: In manual mode the indexed `spi_ss_n` follows the manual-assert bit. It stays low between frames until software clears that bit.
- R9: With loopback set, received bits come from `spi_mosi` and `spi_miso` has no effect. A looped-back frame leaves the data unchanged.
- R10: Busy reads as 1 from the cycle after the start write until the frame ends. Every host write made while busy is ignored.
- R11: `spi_sclk` is low whenever idle, and each phase lasts HALF_DIV system clocks.
- R12: At the end of a frame `irq` pulses high for one cycle if the interrupt enable is set. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NUM_SS | Active-low slave selects |
| irq | output | 1 | Frame-done pulse |

## Verification
On every cycle, the assertions check that the serial clock is low when idle, that a start write raises busy, that at most one select is low and none is low while idle in automatic mode, that control is frozen while busy, and that each interrupt pulse follows the end of a frame. Some behaviour only the directed scenarios can show, because it needs a slave model and knowledge of which bits went where. This covers the bit order of sent and received data for each length and edge choice, the number and width of clock phases, the preservation of bytes above the frame, manual select held across two frames, the loopback result, and writes being dropped during a frame.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;

    localparam int DATA_BYTES = 4;

    typedef struct packed {
        logic       irq_en;
        logic       loopback;
        logic       manual;
        logic       lsb_first;
        logic       sample_fall;
        logic [1:0] len;
    } ctrl_t;

    function automatic int unsigned frame_bits(input logic [1:0] len);
        return (int'(len) + 1) * 8;
    endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(HALF_DIV - 1)) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_tick_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] data_i,
    input  logic [1:0]   len_i,
    input  logic         lsb_first_i,
    input  logic         rx_bit_i,
    output logic         tx_bit_o,
    output logic [W-1:0] shifted_o
);
    import spi_regmaster_pkg::*;

    localparam int IW = $clog2(W);

    int unsigned    nb;
    logic [IW-1:0]  top_idx;
    logic [W-1:0]   mask;
    logic [W-1:0]   keep;

    always_comb begin
        nb      = frame_bits(len_i);
        top_idx = IW'(nb - 1);
        mask    = {W{1'b1}} >> (W - nb);
        keep    = data_i & ~mask;
        if (lsb_first_i) begin
            tx_bit_o  = data_i[0];
            shifted_o = keep | ((data_i & mask) >> 1) | (W'(rx_bit_i) << top_idx);
        end else begin
            tx_bit_o  = data_i[top_idx];
            shifted_o = keep | (((data_i << 1) | W'(rx_bit_i)) & mask);
        end
    end

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_regmaster_pkg::*;
#(
    parameter int NUM_SS   = 4,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_SS-1:0] spi_ss_n,
    output logic              irq
);
    localparam int W   = 8 * DATA_BYTES;
    localparam int SSW = (NUM_SS > 1) ? $clog2(NUM_SS) : 1;
    localparam int ECW = $clog2(2 * W + 1);

    typedef struct packed {
        logic [W-1:0]   data;
        ctrl_t          ctrl;
        logic [SSW-1:0] sel;
        logic           man_ss;
        logic           busy;
        logic           sclk;
        logic           rx_bit;
        logic [ECW-1:0] edge_cnt;
        logic           irq;
    } state_t;

    state_t s_d, s_q;

    logic         tick;
    logic         tx_bit;
    logic [W-1:0] shifted;
    logic         rx_in;
    logic         even_edge;

    spi_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s_q.busy),
        .tick (tick)
    );

    spi_shift_unit #(.W(W)) u_shift (
        .data_i     (s_q.data),
        .len_i      (s_q.ctrl.len),
        .lsb_first_i(s_q.ctrl.lsb_first),
        .rx_bit_i   (s_q.rx_bit),
        .tx_bit_o   (tx_bit),
        .shifted_o  (shifted)
    );

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        rx_in     = s_q.ctrl.loopback ? tx_bit : spi_miso;
        even_edge = ~s_q.edge_cnt[0];
        if (!s_q.busy) begin
            if (reg_we) begin
                case (reg_addr)
                    3'd0, 3'd1, 3'd2, 3'd3: begin
                        s_d.data[8*reg_addr[1:0] +: 8] = reg_wdata;
                        if (reg_addr == 3'd3) begin
                            s_d.busy     = 1'b1;
                            s_d.edge_cnt = '0;
                        end
                    end
                    3'd4: s_d.ctrl = ctrl_t'(reg_wdata[6:0]);
                    3'd5: begin
                        s_d.sel    = reg_wdata[SSW-1:0];
                        s_d.man_ss = reg_wdata[6];
                    end
                    default: ;
                endcase
            end
        end else if (tick) begin
            if (s_q.edge_cnt < ECW'(2 * frame_bits(s_q.ctrl.len))) begin
                s_d.sclk     = ~s_q.sclk;
                s_d.edge_cnt = s_q.edge_cnt + 1'b1;
                if (!s_q.ctrl.sample_fall) begin
                    if (even_edge) s_d.rx_bit = rx_in;
                    else           s_d.data   = shifted;
                end else begin
                    if (!even_edge)                 s_d.rx_bit = rx_in;
                    else if (s_q.edge_cnt != '0)    s_d.data   = shifted;
                end
            end else begin
                if (s_q.ctrl.sample_fall) s_d.data = shifted;
                s_d.busy     = 1'b0;
                s_d.edge_cnt = '0;
                s_d.irq      = s_q.ctrl.irq_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            3'd0, 3'd1, 3'd2, 3'd3: reg_rdata = s_q.data[8*reg_addr[1:0] +: 8];
            3'd4: reg_rdata = {1'b0, s_q.ctrl};
            3'd5: begin
                reg_rdata[7]       = s_q.busy;
                reg_rdata[6]       = s_q.man_ss;
                reg_rdata[SSW-1:0] = s_q.sel;
            end
            default: ;
        endcase
    end

    assign spi_sclk = s_q.sclk;
    assign spi_mosi = tx_bit;
    assign irq      = s_q.irq;

    for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
        assign spi_ss_n[i] = ~((s_q.sel == SSW'(i)) &&
                               (s_q.ctrl.manual ? s_q.man_ss : s_q.busy));
    end

    assert_sclk_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> !spi_sclk);

    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && reg_we && reg_addr == 3'd3) |=> s_q.busy);

    assert_single_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~spi_ss_n) <= 1);

    assert_auto_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.manual && !s_q.busy) |-> (&spi_ss_n));

    assert_ctrl_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> $stable(s_q.ctrl));

    assert_irq_at_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(s_q.busy) && !s_q.busy));

endmodule

// File: tb/sim_spi_regmaster.sv
module sim_spi_regmaster;
    localparam int NUM_SS   = 4;
    localparam int HALF_DIV = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              spi_sclk, spi_mosi;
    logic              spi_miso = 1'b0;
    logic [NUM_SS-1:0] spi_ss_n;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;

    logic              tb_fall = 1'b0;
    logic              slv_bits [0:32];
    logic              mosi_seen [0:31];
    int                k = 0;
    int                j = 0;
    int                rise_cnt = 0;
    int                hi_cycles = 0;
    int                irq_cnt = 0;
    logic              ss_bad = 1'b0;
    logic [NUM_SS-1:0] exp_ss = '1;

    always #4 clk = ~clk;

    spi_regmaster #(.NUM_SS(NUM_SS), .HALF_DIV(HALF_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n), .irq(irq)
    );

    // Slave model
    always @(posedge spi_sclk) begin
        rise_cnt++;
        if (spi_ss_n !== exp_ss) ss_bad = 1'b1;
        if (!tb_fall) begin
            if (j < 32) mosi_seen[j] = spi_mosi;
            j++;
        end else begin
            if (k < 33) spi_miso = slv_bits[k];
            k++;
        end
    end

    always @(negedge spi_sclk) begin
        if (!tb_fall) begin
            k++;
            if (k < 33) spi_miso = slv_bits[k];
        end else begin
            if (j < 32) mosi_seen[j] = spi_mosi;
            j++;
        end
    end

    always @(negedge clk) begin
        if (spi_sclk) hi_cycles++;
        if (irq) irq_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        do begin
            @(negedge clk);
            rd(3'd5, v);
        end while (v[7]);
    endtask

    task automatic read_data(output logic [31:0] w);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), b);
            w[8*i +: 8] = b;
        end
    endtask

    task automatic arm_slave(input logic fall, input logic [31:0] sw, input int idx);
        tb_fall = fall;
        for (int i = 0; i < 32; i++) slv_bits[i] = sw[i];
        slv_bits[32] = 1'b0;
        k = 0; j = 0; rise_cnt = 0; hi_cycles = 0; irq_cnt = 0; ss_bad = 1'b0;
        exp_ss = ~(NUM_SS'(1) << idx);
        spi_miso = fall ? 1'b0 : slv_bits[0];
    endtask

    task automatic test_reset();
        logic [7:0] v;
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), v);
            chk("R1 reset register", 32'(v), 32'h0);
        end
        chk("R1 reset sclk", 32'(spi_sclk), 32'h0);
        chk("R1 reset selects", 32'(spi_ss_n), 32'hF);
        chk("R1 reset irq", 32'(irq), 32'h0);
    endtask

    // General automatic-select frame; slave sends sw bit i as its i-th bit
    task automatic test_frame(input logic [1:0] len, input logic lsb, input logic fall,
                              input int idx, input logic [31:0] txw, input logic [31:0] sw,
                              input string tag);
        int          n;
        logic [31:0] got, exp_rx, exp_tx_seen, seen;
        n = (int'(len) + 1) * 8;
        wr(3'd4, {4'b0000, lsb, fall, len});
        wr(3'd5, 8'(idx));
        for (int i = 0; i < 3; i++) wr(3'(i), txw[8*i +: 8]);
        arm_slave(fall, sw, idx);
        wr(3'd3, txw[31:24]);
        wait_idle();
        read_data(got);
        exp_rx = txw;
        exp_tx_seen = '0;
        seen = '0;
        for (int i = 0; i < n; i++) begin
            if (lsb) begin
                exp_rx[i] = sw[i];
                exp_tx_seen[i] = txw[i];
            end else begin
                exp_rx[n-1-i] = sw[i];
                exp_tx_seen[i] = txw[n-1-i];
            end
            seen[i] = mosi_seen[i];
        end
        chk({tag, " R4/R5/R6 received data"}, got, exp_rx);
        chk({tag, " R4/R5/R6 sent bit order"}, seen, exp_tx_seen);
        chk({tag, " R3 rising edges"}, 32'(rise_cnt), 32'(n));
        chk({tag, " R11 high phase cycles"}, 32'(hi_cycles), 32'(n * HALF_DIV));
        chk({tag, " R7 select during frame"}, 32'(ss_bad), 32'h0);
        chk({tag, " R7 selects idle"}, 32'(spi_ss_n), 32'hF);
        chk({tag, " R12 no irq when disabled"}, 32'(irq_cnt), 32'h0);
    endtask

    task automatic test_start_and_ignore();
        logic [7:0] v;
        wr(3'd4, 8'h20);                  // loopback, 8 bits, rising sample
        wr(3'd5, 8'h01);
        wr(3'd0, 8'hA5);
        wr(3'd1, 8'h3C);
        wr(3'd2, 8'h96);
        rd(3'd5, v);
        chk("R2 no start from low bytes", 32'(v[7]), 32'h0);
        arm_slave(1'b0, 32'hFFFF_FFFF, 1);
        spi_miso = 1'b1;
        wr(3'd3, 8'h00);
        rd(3'd5, v);
        chk("R2 R10 busy after start", 32'(v[7]), 32'h1);
        wr(3'd0, 8'h00);                  // ignored while busy
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h43);
        wait_idle();
        rd(3'd0, v);
        chk("R9 R10 loopback byte kept", 32'(v), 32'hA5);
        rd(3'd1, v);
        chk("R3 byte above frame kept", 32'(v), 32'h3C);
        rd(3'd4, v);
        chk("R10 control write ignored", 32'(v), 32'h20);
        rd(3'd5, v);
        chk("R10 select write ignored", 32'(v), 32'h01);
    endtask

    task automatic test_manual();
        logic [7:0] v;
        wr(3'd4, 8'h10);                  // manual, 8 bits
        wr(3'd5, 8'h42);                  // index 2, asserted
        chk("R8 manual assert", 32'(spi_ss_n), 32'hB);
        arm_slave(1'b0, 32'h0000_005A, 2);
        wr(3'd0, 8'h11);
        wr(3'd3, 8'h00);
        wait_idle();
        chk("R8 held between frames", 32'(spi_ss_n), 32'hB);
        arm_slave(1'b0, 32'h0000_00C3, 2);
        wr(3'd0, 8'h22);
        wr(3'd3, 8'h00);
        wait_idle();
        rd(3'd0, v);
        chk("R8 second frame data", 32'(v), 32'hC3);
        chk("R8 held through frames", 32'(ss_bad), 32'h0);
        wr(3'd5, 8'h02);
        chk("R8 manual release", 32'(spi_ss_n), 32'hF);
    endtask

    task automatic test_irq();
        wr(3'd4, 8'h41);                  // irq enable, 16 bits
        wr(3'd5, 8'h00);
        arm_slave(1'b0, 32'h0000_1234, 0);
        wr(3'd3, 8'h00);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R12 single irq pulse", 32'(irq_cnt), 32'h1);
        chk("R12 irq low after", 32'(irq), 32'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_start_and_ignore();
        test_frame(2'b00, 1'b0, 1'b0, 0, 32'h1122_33C5, 32'h0000_0069, "len8 msb rise");
        test_frame(2'b01, 1'b1, 1'b1, 1, 32'h5566_B28D, 32'h0000_E41F, "len16 lsb fall");
        test_frame(2'b10, 1'b0, 1'b1, 2, 32'h77F0_0F3A, 32'h00A5_5A81, "len24 msb fall");
        test_frame(2'b11, 1'b1, 1'b0, 3, 32'hDEAD_BEEF, 32'h1357_9BDF, "len32 lsb rise");
        test_frame(2'b11, 1'b0, 1'b0, 0, 32'h8000_0001, 32'hC0FF_EE42, "len32 msb rise");
        test_manual();
        test_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule